// File: doc/BRIEF.md
# Multi-Channel Serial Audio Port

This block is the master side of a serial link to audio converters. From the system clock it makes three clocks for the converters: a master clock, a bit clock and a word select. Every audio frame lasts exactly 1024 system clocks and holds 64 bit-clock periods, split into a left slot and a right slot of 32 bits each. Two serial output lines each carry one stereo pair, which gives four output channels. One serial input line carries one stereo pair from an analog-to-digital converter.

Samples are up to 20 bits wide and are held MSB-aligned in parallel registers. A 2-bit format code sets where each sample sits inside its slot. The sample can start one bit after the word-select edge, or it can end on the last bit of the slot at a width of 16, 18 or 20 bits.

The host side is plain parallel registers and has no back-pressure. The block reads the transmit samples and the format code once per frame, on the last clock of the frame. It presents the received pair with a one-cycle valid pulse on the first clock of the next frame. That pulse has no ready: the consumer must take the data in that cycle or read it from the held outputs before the next pulse. The same pulse tells the host that the transmit registers may now be rewritten for the following frame.

Top module: `aud_serial_port`

## Requirements
- R1: A frame is 1024 system clocks, counted from reset release. `wsel` is 0 during clocks 0-511 of the frame (left slot) and 1 during clocks 512-1023 (right slot).
- R2: `mclk` has a period of 4 system clocks (256 periods per frame). It is 0 on frame clocks where (n mod 4) < 2 and 1 otherwise.
- R3: `bclk` has a period of 16 system clocks (64 periods per frame). It is 0 on frame clocks where (n mod 16) < 8 and 1 otherwise.
- R4: `wsel` and every `sdo` line change only on frame clocks where (n mod 16) = 0, which is 8 clocks before the next rising `bclk`.
- R5: Format code 0 (2'b00) is I2S placement. At slot bit position p (p = 0 is the first bit after the slot starts, MSB first), positions 1..20 carry sample bits 19..0.
- R6: Format codes 1, 2 and 3 are right-justified placement with widths of 16, 18 and 20 bits. The top W bits of the 20-bit sample fill slot positions 32-W..31, with the sample's bit 19 at position 32-W.
- R7: Slot positions outside the selected window send 0. Input bits in those positions are ignored: received samples carry 0 in their low 20-W bits.
- R8: The transmit samples and `fmt_sel` are sampled only on frame clock 1023 and take effect for the whole next frame. Changes at other times have no effect until then. After reset the first frame uses format 0 and all-zero samples.
- R9: `sdi` is sampled on each rising `bclk`. The left and right values received during a frame appear on `rx_left` and `rx_right` with `rx_valid` high for exactly one cycle, frame clock 0 of the next frame, and they are held until the next pulse.
- R10: While `rst_n` is low, all outputs are 0.
- R11: Output line k sends `tx_left[k*20 +: 20]` in its left slot and `tx_right[k*20 +: 20]` in its right slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Slot placement code: 0 I2S, 1/2/3 right-justified 16/18/20 |
| tx_left | input | 40 | Left samples, 20 bits per output line, line 0 lowest |
| tx_right | input | 40 | Right samples, 20 bits per output line, line 0 lowest |
| sdi | input | 1 | Serial input data from the converter |
| mclk | output | 1 | Converter master clock, 256 times the sample rate |
| bclk | output | 1 | Serial bit clock |
| wsel | output | 1 | Word select, 0 for the left slot and 1 for the right slot |
| sdo | output | 2 | Serial output data lines |
| rx_left | output | 20 | Received left sample, MSB-aligned |
| rx_right | output | 20 | Received right sample, MSB-aligned |
| rx_valid | output | 1 | One-cycle pulse that presents a received pair |

## Verification
The embedded properties check, on every cycle, the timing relations between the generated clocks and the frame counter. `bclk` rises only in the middle of a bit. `wsel` moves only at the start of a bit, and the data lines hold still across each rising `bclk`. Every slot begins with a zero bit. The receive pulse lasts one cycle and the received words hold steady between pulses. Only the bench's reference model can show bit-exact placement for each format, that settings written mid-frame wait for the frame boundary, and that received words have the right value and exclude bits outside the window. The model runs with changing formats, extreme sample values and a variety of input patterns.

// File: rtl/aud_sp_pkg.sv
package aud_sp_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_RJ16 = 2'd1,
    FMT_RJ18 = 2'd2,
    FMT_RJ20 = 2'd3
  } fmt_e;

  // data width used by a right-justified code
  function automatic int rj_width(fmt_e f);
    case (f)
      FMT_RJ16: return 16;
      FMT_RJ18: return 18;
      FMT_RJ20: return 20;
      default:  return 0;
    endcase
  endfunction

  // Sample bit carried at slot position pos (0 = first bit of slot),
  // or -1 when that position is outside the data window.
  function automatic int slot_index(fmt_e f, int pos, int smp_w, int slot_w);
    int w;
    int start;
    w = rj_width(f);
    if (w > smp_w) w = smp_w;
    start = slot_w - w;
    if (f == FMT_I2S) begin
      if (pos >= 1 && pos <= smp_w) return smp_w - pos;
      return -1;
    end
    if (pos >= start && pos < slot_w) return smp_w - 1 - (pos - start);
    return -1;
  endfunction

endpackage

// File: rtl/aud_sp_clkgen.sv
module aud_sp_clkgen #(
  parameter int BCLK_DIV = 16,
  parameter int MCLK_DIV = 4,
  parameter int SLOT_W   = 32,
  localparam int FRAME   = BCLK_DIV * 2 * SLOT_W,
  localparam int CNT_W   = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             frame_last,
  output logic             mclk,
  output logic             bclk,
  output logic             wsel
);
  localparam int PH_W = $clog2(BCLK_DIV);
  localparam int MC_B = $clog2(MCLK_DIV) - 1;

  assign frame_last = (cnt_q == CNT_W'(FRAME - 1));
  assign cnt_nxt    = frame_last ? '0 : cnt_q + CNT_W'(1);

  // every output is registered from the next count so all move together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mclk  <= 1'b0;
      bclk  <= 1'b0;
      wsel  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      mclk  <= cnt_nxt[MC_B];
      bclk  <= cnt_nxt[PH_W-1];
      wsel  <= cnt_nxt[CNT_W-1];
    end
  end

  // bit clock rises in the middle of a bit period
  p_bclk_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> cnt_q[PH_W-1:0] == PH_W'(BCLK_DIV / 2));

  // word select moves only at the start of a bit period
  p_ws_bit_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wsel) |-> cnt_q[PH_W-1:0] == '0);

  // master clock rises half way through its period
  p_mclk_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk) |-> cnt_q[MC_B:0] == (MC_B+1)'(MCLK_DIV / 2));

endmodule

// File: rtl/aud_sp_tx.sv
module aud_sp_tx
  import aud_sp_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32,
  localparam int BIT_W   = $clog2(2 * SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_last,
  input  logic [BIT_W-1:0]    bitpos_nxt,
  input  fmt_e                fmt_nxt,
  input  logic                bclk,
  input  logic                wsel,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdo
);
  localparam int IW = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic [SAMPLE_W-1:0] nxt_l, nxt_r;
  logic                bit_nxt;
  int                  idx;

  // samples for the coming frame are taken on its last clock
  assign nxt_l = frame_last ? left_i  : hold_l;
  assign nxt_r = frame_last ? right_i : hold_r;

  always_comb begin
    idx = slot_index(fmt_nxt, int'(bitpos_nxt[BIT_W-2:0]), SAMPLE_W, SLOT_W);
    if (idx < 0)
      bit_nxt = 1'b0;
    else if (bitpos_nxt[BIT_W-1])
      bit_nxt = nxt_r[IW'(idx)];
    else
      bit_nxt = nxt_l[IW'(idx)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      sdo    <= 1'b0;
    end else begin
      hold_l <= nxt_l;
      hold_r <= nxt_r;
      sdo    <= bit_nxt;
    end
  end

  // data is steady across each rising bit clock
  p_sdo_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> $stable(sdo));

  generate
    if (SLOT_W > SAMPLE_W) begin : g_lead
      // the first bit of every slot is outside both windows
      p_slot_lead_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wsel) |-> sdo == 1'b0);
    end
  endgenerate

endmodule

// File: rtl/aud_sp_rx.sv
module aud_sp_rx
  import aud_sp_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32,
  parameter int BCLK_DIV = 16,
  localparam int CNT_W   = $clog2(BCLK_DIV * 2 * SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_last,
  input  logic [CNT_W-1:0]    cnt_q,
  input  fmt_e                fmt_q,
  input  logic                sdi,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_valid
);
  localparam int PH_W = $clog2(BCLK_DIV);
  localparam int IW   = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] acc_l, acc_r;
  logic                take;
  int                  idx;

  // the edge ending this clock is the one that raises the bit clock
  assign take = (cnt_q[PH_W-1:0] == PH_W'(BCLK_DIV / 2 - 1));

  always_comb
    idx = slot_index(fmt_q, int'(cnt_q[CNT_W-2:PH_W]), SAMPLE_W, SLOT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_l    <= '0;
      acc_r    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= frame_last;
      if (frame_last) begin
        rx_left  <= acc_l;
        rx_right <= acc_r;
        acc_l    <= '0;
        acc_r    <= '0;
      end else if (take && idx >= 0) begin
        if (cnt_q[CNT_W-1]) acc_r[IW'(idx)] <= sdi;
        else                acc_l[IW'(idx)] <= sdi;
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_sp_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32,
  parameter int BCLK_DIV = 16,
  parameter int MCLK_DIV = 4,
  parameter int N_TX     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               fmt_sel,
  input  logic [N_TX*SAMPLE_W-1:0] tx_left,
  input  logic [N_TX*SAMPLE_W-1:0] tx_right,
  input  logic                     sdi,
  output logic                     mclk,
  output logic                     bclk,
  output logic                     wsel,
  output logic [N_TX-1:0]          sdo,
  output logic [SAMPLE_W-1:0]      rx_left,
  output logic [SAMPLE_W-1:0]      rx_right,
  output logic                     rx_valid
);
  localparam int FRAME = BCLK_DIV * 2 * SLOT_W;
  localparam int CNT_W = $clog2(FRAME);
  localparam int PH_W  = $clog2(BCLK_DIV);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             frame_last;
  fmt_e             fmt_q, fmt_nxt;

  aud_sp_clkgen #(
    .BCLK_DIV(BCLK_DIV), .MCLK_DIV(MCLK_DIV), .SLOT_W(SLOT_W)
  ) u_clk (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .frame_last(frame_last), .mclk(mclk), .bclk(bclk), .wsel(wsel)
  );

  // placement code is frozen for a whole frame
  assign fmt_nxt = frame_last ? fmt_e'(fmt_sel) : fmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fmt_q <= FMT_I2S;
    else        fmt_q <= fmt_nxt;
  end

  generate
    for (genvar k = 0; k < N_TX; k++) begin : g_line
      aud_sp_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .frame_last(frame_last),
        .bitpos_nxt(cnt_nxt[CNT_W-1:PH_W]), .fmt_nxt(fmt_nxt),
        .bclk(bclk), .wsel(wsel),
        .left_i(tx_left[k*SAMPLE_W +: SAMPLE_W]),
        .right_i(tx_right[k*SAMPLE_W +: SAMPLE_W]),
        .sdo(sdo[k])
      );
    end
  endgenerate

  aud_sp_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .BCLK_DIV(BCLK_DIV)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_last(frame_last), .cnt_q(cnt_q),
    .fmt_q(fmt_q), .sdi(sdi), .rx_left(rx_left), .rx_right(rx_right),
    .rx_valid(rx_valid)
  );

endmodule

// File: tb/aud_serial_port_test.sv
module aud_serial_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic [39:0] tx_left = '0, tx_right = '0;
  logic        sdi = 1'b0;
  logic        mclk, bclk, wsel, rx_valid;
  logic [1:0]  sdo;
  logic [19:0] rx_left, rx_right;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  aud_serial_port uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .tx_left(tx_left),
    .tx_right(tx_right), .sdi(sdi), .mclk(mclk), .bclk(bclk), .wsel(wsel),
    .sdo(sdo), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  // model state
  int          c = 0;
  logic [1:0]  cur_fmt = 2'd0;
  logic [19:0] cur_l [2];
  logic [19:0] cur_r [2];
  logic [63:0] cur_pat = '0;
  logic        exp_valid = 1'b0;
  logic [19:0] exp_l = '0, exp_r = '0;

  function automatic logic [31:0] tx_slot(logic [1:0] f, logic [19:0] s);
    case (f)
      2'd0:    return {1'b0, s, 11'b0};
      2'd1:    return {16'b0, s[19:4]};
      2'd2:    return {14'b0, s[19:2]};
      default: return {12'b0, s};
    endcase
  endfunction

  function automatic logic [19:0] rx_slot(logic [1:0] f, logic [31:0] s);
    case (f)
      2'd0:    return s[30:11];
      2'd1:    return {s[15:0], 4'b0};
      2'd2:    return {s[17:0], 2'b0};
      default: return s[19:0];
    endcase
  endfunction

  task automatic chk(string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails < 20)
        $display("FAIL %s at frame clock %0d: actual %h expected %h", req, c, act, exp);
    end
  endtask

  task automatic check_cycle();
    int b;
    logic [31:0] w;
    b = c >> 4;
    chk("R1 wsel", 20'(wsel), 20'((c >> 9) & 1));
    chk("R2 mclk", 20'(mclk), 20'((c >> 1) & 1));
    chk("R3 bclk", 20'(bclk), 20'((c >> 3) & 1));
    for (int k = 0; k < 2; k++) begin
      w = tx_slot(cur_fmt, (b >= 32) ? cur_r[k] : cur_l[k]);
      chk("R4 R5 R6 R7 R8 R11 sdo", 20'(sdo[k]), 20'(w[31 - (b % 32)]));
    end
    chk("R9 rx_valid", 20'(rx_valid), 20'(exp_valid));
    if (exp_valid) begin
      chk("R5 R6 R7 R9 rx_left", rx_left, exp_l);
      chk("R5 R6 R7 R9 rx_right", rx_right, exp_r);
    end
  endtask

  task automatic set_frame_inputs(int f);
    logic [1:0] fm;
    fm = 2'(f % 4);
    fmt_sel = fm;
    if (f == 4) begin
      tx_left = '1; tx_right = '1;
    end else if (f == 5) begin
      tx_left = {20'h00001, 20'h80000}; tx_right = {20'h80000, 20'h00001};
    end else if (f == 9) begin
      tx_left = '0; tx_right = '0;
    end else begin
      tx_left  = {20'($urandom), 20'($urandom)};
      tx_right = {20'($urandom), 20'($urandom)};
    end
  endtask

  function automatic logic [63:0] pick_pat(int f);
    if (f == 5 || f == 7) return '1;
    if (f == 6) return 64'h0;
    return {$urandom, $urandom};
  endfunction

  initial begin
    int frame;
    frame = 0;
    for (int k = 0; k < 2; k++) begin cur_l[k] = '0; cur_r[k] = '0; end
    repeat (3) @(negedge clk);
    // R10: everything low while reset is held
    chk("R10 reset mclk", 20'(mclk), 20'h0);
    chk("R10 reset bclk", 20'(bclk), 20'h0);
    chk("R10 reset wsel", 20'(wsel), 20'h0);
    chk("R10 reset sdo", 20'(sdo), 20'h0);
    chk("R10 reset rx_valid", 20'(rx_valid), 20'h0);
    chk("R10 reset rx_left", rx_left, 20'h0);
    // fill inputs during reset: first frame must still send zeros (R8)
    tx_left = '1; tx_right = '1; fmt_sel = 2'd3;
    cur_pat = pick_pat(0);
    rst_n = 1'b1;
    while (frame < 13) begin
      check_cycle();
      sdi = cur_pat[63 - (c >> 4)];
      if (c == 500) set_frame_inputs(frame + 1);
      @(posedge clk);
      if (c == 1023) begin
        exp_valid = 1'b1;
        exp_l = rx_slot(cur_fmt, cur_pat[63:32]);
        exp_r = rx_slot(cur_fmt, cur_pat[31:0]);
        cur_fmt = fmt_sel;
        for (int k = 0; k < 2; k++) begin
          cur_l[k] = tx_left[k*20 +: 20];
          cur_r[k] = tx_right[k*20 +: 20];
        end
        frame++;
        cur_pat = pick_pat(frame);
        c = 0;
      end else begin
        exp_valid = 1'b0;
        c++;
      end
      @(negedge clk);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at frame clock %0d", c);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule